// File: doc/BRIEF.md
# Battery Protection and Power-Mode Controller

This block decides how a battery-backed supply runs. From a set of digital condition flags (supplied by analog comparators elsewhere) and a free-running millisecond tick, it selects one of five operating modes: powered from the input, powered from the battery, shutdown, over-discharge off, or fault off. The mode drives the enables for the system rail, the regulator and the battery-measure path. A charge-path enable is further gated by two latched charge faults: battery overcharge and die over-temperature.

Each protective condition has its own qualification time, counted in ticks, and each mode has its own exit rule. Some faults clear only when the input is reconnected, and a wake-up request counts only while the battery is above its release level. When a valid input is present, the shutdown and wake-up pins are ignored, and so are the battery-side protections.

Top module: `batt_pwr_ctrl`

## Requirements
- R1: After reset the block is in shutdown: `sys_en`, `ldo_en`, `chg_en` and `meas_en` are 0 and `fault` is 5'b00000.
- R2: In battery mode with no valid input, `batt_low` held for `ODC_MS` ticks enters over-discharge off: all enables drop on the next clock and `fault[4]` rises. After `ODC_MS` ticks the mode has not yet changed.
- R3: From over-discharge off, a valid input enters input mode on the next clock. If the input is removed before `batt_rel` has been seen in input mode, the block returns to over-discharge off. Once `batt_rel` has been seen, `fault[4]` clears and removing the input enters battery mode.
- R4: In battery mode, `dis_oc` held for `OCP_MS` ticks enters fault off and sets `fault[2]`. A valid input, or `wake_pin` qualified as in R6, restores operation and clears `fault[2]`.
- R5: In battery mode, `rail_short` enters fault off on the next clock with no deglitch and sets `fault[3]`.
- R6: In battery mode, `shdn_pin` high with `wake_pin` low enters shutdown. `shdn_pin` is ignored in input mode. Shutdown is left for input mode when `in_ok` is held `INQ_MS` ticks, or for battery mode when `wake_pin` and `batt_rel` are held together `WAKE_MS` ticks. `wake_pin` alone, without `batt_rel`, never exits.
- R7: While `shdn_pin` stays high, battery mode lasts only while `wake_pin` is high. `wake_pin` has no effect while `in_ok` is high.
- R8: `ovchg` held for `OVC_MS` ticks with `in_ok` high drops `chg_en` and sets `fault[0]`. Both stay that way after `ovchg` falls, until the input is reconnected.
- R9: `die_hot` drops `chg_en` and sets `fault[1]` on the next clock. Both stay that way until the input is reconnected.
- R10: `meas_en` equals `meas_req` while the mode is input or battery and neither `dis_oc` nor `rail_short` is high; otherwise it is 0.
- R11: An input reconnect is a rise of `in_ok` after at least one tick with `in_ok` low. A rise with no tick seen while low does not clear `fault[0]` or `fault[1]`.
- R12: `sys_en` and `ldo_en` are 1 exactly in input and battery modes. `chg_en` is 1 only in input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| in_ok | input | 1 | Input supply within its valid window |
| batt_low | input | 1 | Battery below the over-discharge threshold |
| batt_rel | input | 1 | Battery above the release threshold |
| dis_oc | input | 1 | Discharge overcurrent seen |
| rail_short | input | 1 | System rail shorted |
| ovchg | input | 1 | Battery above the overcharge threshold |
| die_hot | input | 1 | Die over-temperature |
| shdn_pin | input | 1 | Shutdown request |
| wake_pin | input | 1 | Wake-up request |
| meas_req | input | 1 | Battery-measure path requested |
| sys_en | output | 1 | System rail enable |
| ldo_en | output | 1 | Regulator enable |
| chg_en | output | 1 | Charge path enable |
| meas_en | output | 1 | Battery-measure path enable |
| fault | output | 5 | Fault flags: [0] overcharge, [1] over-temperature, [2] overcurrent, [3] rail short, [4] over-discharge pending |

## Verification
Directed sequences hold each fault flag for exactly the qualifying tick count and for one tick more, so an off-by-one in any deglitch counter shows up. The mode paths are then walked: out of over-discharge with a premature input removal, restore by wake-up with and without `batt_rel`, and shutdown held open only while wake-up lasts. Two reconnect patterns, one with the tick held low while the input is off and one with it running, tell a true reconnect from a glitch. A random phase sprays battery-side flags, shutdown, wake-up and measure requests while the input is valid, and checks that the enables stay on and that the measure gate follows its function.

// File: rtl/pwr_pkg.sv
// Package: shared mode encoding and fault-bit positions for the power-mode controller.
// Assumes: consumers index the fault vector with the F_* constants.
package pwr_pkg;
    typedef enum logic [2:0] {
        M_SHDN  = 3'd0,
        M_BATT  = 3'd1,
        M_INPUT = 3'd2,
        M_ODIS  = 3'd3,
        M_FOFF  = 3'd4
    } pmode_t;

    localparam int F_OVCHG = 0;
    localparam int F_OTEMP = 1;
    localparam int F_OCP   = 2;
    localparam int F_SHORT = 3;
    localparam int F_ODIS  = 4;
    localparam int NFLT    = 5;
endpackage

// File: rtl/pwr_qual.sv
// Module: tick-based qualifier. Counts ticks while cond is high, clears at once when it drops.
// done is high while cond is high and LIMIT ticks have been counted.
// Assumes: LIMIT >= 1; tick is a single-cycle pulse.
module pwr_qual #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating tick counter, cleared whenever the condition is absent.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (!cond)                  cnt <= '0;
        else if (tick && cnt != LIM_V)   cnt <= cnt + 1'b1;
    end

    // Qualified output.
    assign done = cond && (cnt == LIM_V);

    p_clear_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));
endmodule

// File: rtl/pwr_reconnect.sv
// Module: input reconnect detector. Pulses reconn for one cycle when in_ok rises
// after at least one tick was seen with in_ok low.
// Assumes: in_ok is synchronous to clk.
module pwr_reconnect (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic in_ok,
    output logic reconn
);
    logic low_seen;

    // Remember a tick spent with the input absent; forget it once input returns.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_seen <= 1'b0;
        else if (in_ok)          low_seen <= 1'b0;
        else if (tick)           low_seen <= 1'b1;
    end

    // First cycle of a valid input after a qualified absence.
    assign reconn = in_ok && low_seen;

    p_reconn_after_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reconn |-> !$past(in_ok));
endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: operating-mode state machine with over-discharge pending flag and
// fault-off cause flags.
// Assumes: all qualified inputs come from pwr_qual instances driven by the same tick.
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_ok,
    input  logic   in_q,
    input  logic   wake_q,
    input  logic   wake_pin,
    input  logic   shdn_pin,
    input  logic   rail_short,
    input  logic   ocp_q,
    input  logic   odc_q,
    input  logic   batt_rel,
    output pmode_t mode,
    output logic   odis_pend,
    output logic   ocp_flag,
    output logic   short_flag
);
    pmode_t nxt;

    // Next-mode selection; input presence has top priority in every mode.
    always_comb begin
        nxt = mode;
        case (mode)
            M_INPUT: if (!in_ok) nxt = odis_pend ? M_ODIS : M_BATT;
            M_BATT: begin
                if (in_ok)                      nxt = M_INPUT;
                else if (rail_short || ocp_q)   nxt = M_FOFF;
                else if (odc_q)                 nxt = M_ODIS;
                else if (shdn_pin && !wake_pin) nxt = M_SHDN;
            end
            M_SHDN: begin
                if (in_q)        nxt = M_INPUT;
                else if (wake_q) nxt = M_BATT;
            end
            M_ODIS: if (in_ok) nxt = M_INPUT;
            M_FOFF: begin
                if (in_ok)       nxt = M_INPUT;
                else if (wake_q) nxt = M_BATT;
            end
            default: nxt = M_SHDN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_SHDN;
        else        mode <= nxt;
    end

    // Over-discharge pending: set on entry, cleared once release is seen on input power.
    always_ff @(posedge clk) begin
        if (!rst_n)                                odis_pend <= 1'b0;
        else if (mode != M_ODIS && nxt == M_ODIS)  odis_pend <= 1'b1;
        else if (mode == M_INPUT && batt_rel)      odis_pend <= 1'b0;
    end

    // Fault-off cause flags: recorded on entry, cleared on leaving fault off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocp_flag   <= 1'b0;
            short_flag <= 1'b0;
        end else if (mode == M_BATT && nxt == M_FOFF) begin
            short_flag <= rail_short;
            ocp_flag   <= ocp_q;
        end else if (mode == M_FOFF && nxt != M_FOFF) begin
            short_flag <= 1'b0;
            ocp_flag   <= 1'b0;
        end
    end

    p_short_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BATT && !in_ok && rail_short) |=> (mode == M_FOFF));
    p_input_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_INPUT && in_ok) |=> (mode == M_INPUT));
    p_odis_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_INPUT && !in_ok && odis_pend) |=> (mode == M_ODIS));
endmodule

// File: rtl/batt_pwr_ctrl.sv
// Module: top of the battery protection and power-mode controller.
// Builds the per-condition qualifiers, the reconnect detector, the mode FSM,
// the charge-fault latches and the output decode.
// Assumes: tick pulses once per millisecond; all flags are synchronous to clk.
module batt_pwr_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned ODC_MS  = 60,
    parameter int unsigned OCP_MS  = 10,
    parameter int unsigned INQ_MS  = 240,
    parameter int unsigned WAKE_MS = 1200,
    parameter int unsigned OVC_MS  = 1200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            in_ok,
    input  logic            batt_low,
    input  logic            batt_rel,
    input  logic            dis_oc,
    input  logic            rail_short,
    input  logic            ovchg,
    input  logic            die_hot,
    input  logic            shdn_pin,
    input  logic            wake_pin,
    input  logic            meas_req,
    output logic            sys_en,
    output logic            ldo_en,
    output logic            chg_en,
    output logic            meas_en,
    output logic [NFLT-1:0] fault
);
    localparam int Q_IN   = 0;
    localparam int Q_WAKE = 1;
    localparam int Q_ODC  = 2;
    localparam int Q_OCP  = 3;
    localparam int Q_OVC  = 4;
    localparam int NQ     = 5;
    localparam int unsigned LIMS [NQ] = '{INQ_MS, WAKE_MS, ODC_MS, OCP_MS, OVC_MS};

    pmode_t        mode;
    logic [NQ-1:0] q_cond;
    logic [NQ-1:0] q_done;
    logic          reconn;
    logic          odis_pend, ocp_flag, short_flag;
    logic          ovc_lat, otemp_lat;
    logic          on_mode;

    // Qualification conditions for each deglitched event.
    always_comb begin
        q_cond         = '0;
        q_cond[Q_IN]   = in_ok;
        q_cond[Q_WAKE] = wake_pin && batt_rel && !in_ok;
        q_cond[Q_ODC]  = batt_low && !in_ok && (mode == M_BATT);
        q_cond[Q_OCP]  = dis_oc && !in_ok && (mode == M_BATT);
        q_cond[Q_OVC]  = ovchg && in_ok;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_qual
        pwr_qual #(.LIMIT(LIMS[q])) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .cond (q_cond[q]),
            .done (q_done[q])
        );
    end

    pwr_reconnect u_reconn (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .in_ok (in_ok),
        .reconn(reconn)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_ok     (in_ok),
        .in_q      (q_done[Q_IN]),
        .wake_q    (q_done[Q_WAKE]),
        .wake_pin  (wake_pin),
        .shdn_pin  (shdn_pin),
        .rail_short(rail_short),
        .ocp_q     (q_done[Q_OCP]),
        .odc_q     (q_done[Q_ODC]),
        .batt_rel  (batt_rel),
        .mode      (mode),
        .odis_pend (odis_pend),
        .ocp_flag  (ocp_flag),
        .short_flag(short_flag)
    );

    // Overcharge latch: set by qualified overcharge, cleared only by reconnect.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovc_lat <= 1'b0;
        else if (q_done[Q_OVC])  ovc_lat <= 1'b1;
        else if (reconn)         ovc_lat <= 1'b0;
    end

    // Over-temperature latch: set while hot, cleared only by reconnect.
    always_ff @(posedge clk) begin
        if (!rst_n)       otemp_lat <= 1'b0;
        else if (die_hot) otemp_lat <= 1'b1;
        else if (reconn)  otemp_lat <= 1'b0;
    end

    // Output decode from mode, latches and live fault flags.
    always_comb begin
        on_mode          = (mode == M_INPUT) || (mode == M_BATT);
        sys_en           = on_mode;
        ldo_en           = on_mode;
        chg_en           = (mode == M_INPUT) && !ovc_lat && !otemp_lat;
        meas_en          = meas_req && on_mode && !dis_oc && !rail_short;
        fault            = '0;
        fault[F_OVCHG]   = ovc_lat;
        fault[F_OTEMP]   = otemp_lat;
        fault[F_OCP]     = ocp_flag;
        fault[F_SHORT]   = short_flag;
        fault[F_ODIS]    = odis_pend;
    end

    p_ovc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_lat && !reconn) |=> ovc_lat);
    p_otemp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (otemp_lat && !reconn) |=> otemp_lat);
endmodule

// File: tb/sim_batt_pwr_ctrl.sv
// Bench for batt_pwr_ctrl: directed corner cases plus a seeded random phase.
module sim_batt_pwr_ctrl;
    localparam int ODC = 60, OCP = 10, INQ = 240, WAKE = 1200, OVC = 1200;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic in_ok = 0, batt_low = 0, batt_rel = 0, dis_oc = 0, rail_short = 0;
    logic ovchg = 0, die_hot = 0, shdn_pin = 0, wake_pin = 0, meas_req = 0;
    logic sys_en, ldo_en, chg_en, meas_en;
    logic [4:0] fault;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    batt_pwr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_ok(in_ok), .batt_low(batt_low),
        .batt_rel(batt_rel), .dis_oc(dis_oc), .rail_short(rail_short), .ovchg(ovchg),
        .die_hot(die_hot), .shdn_pin(shdn_pin), .wake_pin(wake_pin), .meas_req(meas_req),
        .sys_en(sys_en), .ldo_en(ldo_en), .chg_en(chg_en), .meas_en(meas_en), .fault(fault)
    );

    function automatic logic exp_meas(logic on, logic req, logic oc, logic sh);
        return req && on && !oc && !sh;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 sys", 8'(sys_en), 0);
        chk("R1 ldo", 8'(ldo_en), 0);
        chk("R1 chg", 8'(chg_en), 0);
        chk("R1 fault", 8'(fault), 0);

        // R6 exit shutdown by held input
        in_ok = 1;
        step(INQ);
        chk("R6 input not yet qualified", 8'(sys_en), 0);
        step(1);
        chk("R6 input qualified", 8'(sys_en), 1);
        chk("R12 chg in input mode", 8'(chg_en), 1);

        // R6/R7 shutdown and wake ignored with input
        shdn_pin = 1; step(5);
        chk("R6 shdn ignored on input", 8'(sys_en), 1);
        wake_pin = 1; batt_rel = 1; step(WAKE + 2);
        chk("R7 wake ignored on input", 8'(chg_en), 1);
        shdn_pin = 0; wake_pin = 0; batt_rel = 0;

        // R12 battery mode
        in_ok = 0; step(1);
        chk("R12 batt sys", 8'(sys_en), 1);
        chk("R12 batt ldo", 8'(ldo_en), 1);
        chk("R12 batt chg", 8'(chg_en), 0);

        // R2 over-discharge boundary
        batt_low = 1; step(ODC);
        chk("R2 before limit", 8'(sys_en), 1);
        step(1);
        chk("R2 over-discharge off", 8'(sys_en), 0);
        chk("R2 flag", 8'(fault[4]), 1);
        batt_low = 0;

        // R3 return to over-discharge without release
        in_ok = 1; step(1);
        chk("R3 input restores", 8'(sys_en), 1);
        in_ok = 0; step(1);
        chk("R3 back to odis", 8'(sys_en), 0);
        chk("R3 pend kept", 8'(fault[4]), 1);
        in_ok = 1; step(1);
        batt_rel = 1; step(1);
        chk("R3 pend cleared", 8'(fault[4]), 0);
        in_ok = 0; step(1);
        chk("R3 battery mode after release", 8'(sys_en), 1);

        // R10 measure gating
        meas_req = 1; #1;
        chk("R10 meas on", 8'(meas_en), 1);
        // R4 overcurrent boundary
        dis_oc = 1; #1;
        chk("R10 meas opened by oc", 8'(meas_en), 0);
        step(OCP);
        chk("R4 before limit", 8'(sys_en), 1);
        step(1);
        chk("R4 fault off", 8'(sys_en), 0);
        chk("R4 flag", 8'(fault[2]), 1);
        dis_oc = 0; #1;
        chk("R10 meas off when off", 8'(meas_en), 0);

        // R4 restore by wake
        wake_pin = 1; step(WAKE);
        chk("R4 wake not yet", 8'(sys_en), 0);
        step(1);
        chk("R4 wake restores", 8'(sys_en), 1);
        chk("R4 flag cleared", 8'(fault[2]), 0);

        // R7 on only while wake lasts
        shdn_pin = 1; step(3);
        chk("R7 held by wake", 8'(sys_en), 1);
        wake_pin = 0; step(1);
        chk("R7 shutdown on wake drop", 8'(sys_en), 0);
        chk("R7 no fault", 8'(fault), 0);

        // R6 wake without release does not exit
        batt_rel = 0; wake_pin = 1; step(WAKE + 5);
        chk("R6 no exit without release", 8'(sys_en), 0);
        batt_rel = 1; step(WAKE);
        chk("R6 wake qualifying", 8'(sys_en), 0);
        step(1);
        chk("R6 wake exits", 8'(sys_en), 1);
        shdn_pin = 0; wake_pin = 0; step(1);

        // R5 rail short
        rail_short = 1; step(1);
        chk("R5 short off", 8'(sys_en), 0);
        chk("R5 flag", 8'(fault[3]), 1);
        rail_short = 0;
        in_ok = 1; step(1);
        chk("R5 input restores", 8'(chg_en), 1);
        chk("R5 flags clear", 8'(fault), 0);

        // R8 overcharge
        ovchg = 1; step(OVC);
        chk("R8 before limit", 8'(chg_en), 1);
        step(1);
        chk("R8 charge off", 8'(chg_en), 0);
        chk("R8 flag", 8'(fault[0]), 1);
        ovchg = 0; step(3);
        chk("R8 latched", 8'(chg_en), 0);

        // R11 glitch without tick does not clear
        tick = 0; in_ok = 0; step(2);
        in_ok = 1; step(1);
        chk("R11 no reconnect", 8'(fault[0]), 1);
        tick = 1; in_ok = 0; step(1);
        in_ok = 1; step(1);
        chk("R11 reconnect clears", 8'(fault[0]), 0);
        chk("R8 charge back", 8'(chg_en), 1);

        // R9 over-temperature
        die_hot = 1; step(1);
        chk("R9 charge off", 8'(chg_en), 0);
        chk("R9 flag", 8'(fault[1]), 1);
        die_hot = 0; step(2);
        chk("R9 latched", 8'(chg_en), 0);
        in_ok = 0; step(1);
        in_ok = 1; step(1);
        chk("R9 reconnect clears", 8'(fault[1]), 0);

        // Random phase on input power: R10, R12
        for (int i = 0; i < 300; i++) begin
            meas_req   = 1'($urandom);
            dis_oc     = 1'($urandom);
            rail_short = 1'($urandom);
            shdn_pin   = 1'($urandom);
            wake_pin   = 1'($urandom);
            batt_low   = 1'($urandom);
            batt_rel   = 1'($urandom);
            step(1);
            chk("R12 random sys", 8'(sys_en), 1);
            chk("R12 random chg", 8'(chg_en), 1);
            chk("R10 random meas", 8'(meas_en), 8'(exp_meas(1'b1, meas_req, dis_oc, rail_short)));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule